// File: doc/BRIEF.md
# Dual-Stream Alignment Error Monitor

This block joins two sample streams. One is produced on this device. The other arrives from a neighbouring device over a chip-to-chip link. Local beats are pushed into a small FIFO so that they can wait for the remote stream. Each remote beat then pops the oldest local beat, and the pair leaves the block one cycle later as a single merged beat.

While the streams are being joined, the block watches for three faults:

- **Packet-boundary disagreement.** The start-of-packet or end-of-packet marks on the remote beat differ from those on the local beat it is paired with.
- **Write into a full FIFO.** This means the remote stream is late or has stopped.
- **Read from an empty FIFO.** This means the remote stream runs ahead of the local one.

Each fault is latched in its own sticky flag. The flags are reduced to one health bit. A status-read strobe clears the flags.

Top module: `stream_align_monitor`

## Requirements
- R1: After reset, all error flags are 0, `healthy` is 1, `merge_valid` is 0 and the FIFO holds no entries.
- R2: Local beats are stored in arrival order together with their boundary marks. A remote beat taken while the FIFO is not empty pops the oldest entry. On the next cycle, `merge_valid` is 1, `merge_loc_data` carries the popped data and `merge_rem_data` carries the remote data.
- R3: A local beat offered while the FIFO holds DEPTH entries is discarded, even if a pop happens in the same cycle. It sets flag bit 1 (overflow) on the next cycle.
- R4: A remote beat offered while the FIFO is empty pops nothing. `merge_valid` stays 0 on the next cycle, and flag bit 2 (underflow) is set.
- R5: On a successful pop, if the remote start mark differs from the popped start mark, or the remote end mark differs from the popped end mark, flag bit 0 (misalignment) is set on the next cycle.
- R6: A flag, once set, stays set until a clear strobe.
- R7: A clear strobe (`clear_rd`) zeroes every flag on the next cycle. An error detected in the same cycle as the strobe still shows afterwards.
- R8: `healthy` is 1 exactly when all three flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| loc_valid | input | 1 | Local beat present (FIFO push) |
| loc_sop | input | 1 | Local start-of-packet mark |
| loc_eop | input | 1 | Local end-of-packet mark |
| loc_data | input | W | Local sample |
| rem_valid | input | 1 | Remote beat present (FIFO pop) |
| rem_sop | input | 1 | Remote start-of-packet mark |
| rem_eop | input | 1 | Remote end-of-packet mark |
| rem_data | input | W | Remote sample |
| clear_rd | input | 1 | Status-read strobe, clears flags |
| merge_valid | output | 1 | Merged beat valid |
| merge_loc_data | output | W | Local half of merged beat |
| merge_rem_data | output | W | Remote half of merged beat |
| err_flags | output | 3 | Sticky flags: bit0 misalignment, bit1 overflow, bit2 underflow |
| healthy | output | 1 | 1 when no flag is set |

## Verification
The assertions assume that the inputs change only away from the rising edge. They also assume that a strobe lasts exactly one cycle per beat, so every cycle in which `loc_valid` or `rem_valid` is high counts as one push or pop request.

The bench drives all inputs one nanosecond after each edge. It draws valid, boundary and clear patterns at random, and forces the remote marks to match the queued head most of the time, so that merges both with and without misalignment occur. Directed phases fill the FIFO past capacity, drain an empty FIFO, and land a clear on the same cycle as a fault.

// File: rtl/sam_pkg.sv
package sam_pkg;
  localparam int ERR_MISALIGN  = 0;
  localparam int ERR_OVERFLOW  = 1;
  localparam int ERR_UNDERFLOW = 2;
  localparam int N_ERR         = 3;

  typedef logic [N_ERR-1:0] err_vec_t;

  // true when both boundary marks agree between the two beats
  function automatic logic bounds_agree(input logic a_sop, input logic a_eop,
                                        input logic b_sop, input logic b_eop);
    return (a_sop == b_sop) && (a_eop == b_eop);
  endfunction
endpackage

// File: rtl/sam_fifo.sv
module sam_fifo #(
  parameter int EW    = 18,
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_req,
  input  logic [EW-1:0]              wr_word,
  input  logic                       rd_req,
  output logic [EW-1:0]              head,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       wr_drop,
  output logic                       rd_miss,
  output logic                       rd_fire
);
  localparam int AW = $clog2(DEPTH);

  logic [EW-1:0] mem [DEPTH];
  logic [AW:0]   wr_ptr, rd_ptr;
  logic          wr_fire;

  assign level   = wr_ptr - rd_ptr;
  assign full    = (level == (AW+1)'(DEPTH));
  assign empty   = (level == '0);
  assign wr_fire = wr_req && !full;
  assign wr_drop = wr_req && full;
  assign rd_fire = rd_req && !empty;
  assign rd_miss = rd_req && empty;
  assign head    = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (wr_fire) mem[wr_ptr[AW-1:0]] <= wr_word;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
    end else begin
      if (wr_fire) wr_ptr <= wr_ptr + 1'b1;
      if (rd_fire) rd_ptr <= rd_ptr + 1'b1;
    end
  end
endmodule

// File: rtl/sam_sticky.sv
module sam_sticky #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clear,
  input  logic [N-1:0] events,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= (flags[i] && !clear) || events[i];
    end
  end
endmodule

// File: rtl/stream_align_monitor.sv
module stream_align_monitor
  import sam_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         loc_valid,
  input  logic         loc_sop,
  input  logic         loc_eop,
  input  logic [W-1:0] loc_data,
  input  logic         rem_valid,
  input  logic         rem_sop,
  input  logic         rem_eop,
  input  logic [W-1:0] rem_data,
  input  logic         clear_rd,
  output logic         merge_valid,
  output logic [W-1:0] merge_loc_data,
  output logic [W-1:0] merge_rem_data,
  output logic [2:0]   err_flags,
  output logic         healthy
);
  localparam int EW = W + 2;
  localparam int LW = $clog2(DEPTH) + 1;

  // named internal events for the bound checker
  logic [EW-1:0] head_word;
  logic          fifo_full, fifo_empty;
  logic [LW-1:0] fifo_level;
  logic          ev_overflow, ev_underflow, pop_fire, ev_misalign;
  err_vec_t      ev_vec, flags_q;

  sam_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (loc_valid),
    .wr_word ({loc_sop, loc_eop, loc_data}),
    .rd_req  (rem_valid),
    .head    (head_word),
    .full    (fifo_full),
    .empty   (fifo_empty),
    .level   (fifo_level),
    .wr_drop (ev_overflow),
    .rd_miss (ev_underflow),
    .rd_fire (pop_fire)
  );

  assign ev_misalign = pop_fire &&
    !bounds_agree(head_word[EW-1], head_word[EW-2], rem_sop, rem_eop);

  always_comb begin
    ev_vec                = '0;
    ev_vec[ERR_MISALIGN]  = ev_misalign;
    ev_vec[ERR_OVERFLOW]  = ev_overflow;
    ev_vec[ERR_UNDERFLOW] = ev_underflow;
  end

  sam_sticky #(.N(N_ERR)) u_sticky (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear_rd),
    .events (ev_vec),
    .flags  (flags_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      merge_valid    <= 1'b0;
      merge_loc_data <= '0;
      merge_rem_data <= '0;
    end else begin
      merge_valid <= pop_fire;
      if (pop_fire) begin
        merge_loc_data <= head_word[W-1:0];
        merge_rem_data <= rem_data;
      end
    end
  end

  assign err_flags = flags_q;
  assign healthy   = (flags_q == '0);
endmodule

// File: rtl/sam_checker.sv
module sam_checker #(
  parameter int DEPTH = 8,
  parameter int LW    = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          loc_valid,
  input logic          rem_valid,
  input logic          clear_rd,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic [LW-1:0] fifo_level,
  input logic          merge_valid,
  input logic [2:0]    err_flags,
  input logic          healthy
);
  assert_pop_merges_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rem_valid && !fifo_empty |=> merge_valid);

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_valid && fifo_full |=> err_flags[1]);

  assert_level_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= LW'(DEPTH));

  assert_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rem_valid && fifo_empty |=> err_flags[2] && !merge_valid);

  assert_underflow_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rem_valid && fifo_empty && !loc_valid |=> fifo_level == '0);

  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_rd |=> (err_flags & $past(err_flags)) == $past(err_flags));

  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clear_rd && !loc_valid && !rem_valid |=> err_flags == 3'b000 && healthy);
endmodule

bind stream_align_monitor sam_checker #(.DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .loc_valid   (loc_valid),
  .rem_valid   (rem_valid),
  .clear_rd    (clear_rd),
  .fifo_full   (fifo_full),
  .fifo_empty  (fifo_empty),
  .fifo_level  (fifo_level),
  .merge_valid (merge_valid),
  .err_flags   (err_flags),
  .healthy     (healthy)
);

// File: tb/sim_stream_align_monitor.sv
`timescale 1ns/1ps
module sim_stream_align_monitor;
  localparam int W     = 16;
  localparam int DEPTH = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         loc_valid = 0, loc_sop = 0, loc_eop = 0;
  logic [W-1:0] loc_data = '0;
  logic         rem_valid = 0, rem_sop = 0, rem_eop = 0;
  logic [W-1:0] rem_data = '0;
  logic         clear_rd = 0;
  logic         merge_valid, healthy;
  logic [W-1:0] merge_loc_data, merge_rem_data;
  logic [2:0]   err_flags;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  stream_align_monitor #(.W(W), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n),
    .loc_valid(loc_valid), .loc_sop(loc_sop), .loc_eop(loc_eop), .loc_data(loc_data),
    .rem_valid(rem_valid), .rem_sop(rem_sop), .rem_eop(rem_eop), .rem_data(rem_data),
    .clear_rd(clear_rd), .merge_valid(merge_valid),
    .merge_loc_data(merge_loc_data), .merge_rem_data(merge_rem_data),
    .err_flags(err_flags), .healthy(healthy)
  );

  // bench model: entries are {sop, eop, data}
  logic [W+1:0] q[$];
  logic [2:0]   m_flags = '0;

  function automatic logic [2:0] events_of(input int size, input logic [W+1:0] hd,
                                           input logic lv, input logic rv,
                                           input logic rs, input logic re);
    logic [2:0] e = '0;
    if (rv && size > 0 && (hd[W+1] != rs || hd[W] != re)) e[0] = 1'b1;
    if (lv && size == DEPTH) e[1] = 1'b1;
    if (rv && size == 0) e[2] = 1'b1;
    return e;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  // one clock with model update and output comparison
  task automatic step();
    logic [W+1:0] hd;
    logic [2:0]   ev;
    logic         exp_mv;
    int           sz;
    sz = q.size();
    hd = (sz > 0) ? q[0] : '0;
    ev = events_of(sz, hd, loc_valid, rem_valid, rem_sop, rem_eop);
    exp_mv = rem_valid && sz > 0;
    if (exp_mv) void'(q.pop_front());
    if (loc_valid && sz < DEPTH) q.push_back({loc_sop, loc_eop, loc_data});
    m_flags = (clear_rd ? 3'b000 : m_flags) | ev;
    @(posedge clk); #1;
    check("R2 merge_valid", 32'(merge_valid), 32'(exp_mv));
    if (exp_mv) begin
      check("R2 local data", 32'(merge_loc_data), 32'(hd[W-1:0]));
      check("R2 remote data", 32'(merge_rem_data), 32'(rem_data));
    end
    check("R5 misalign flag", 32'(err_flags[0]), 32'(m_flags[0]));
    check("R3 overflow flag", 32'(err_flags[1]), 32'(m_flags[1]));
    check("R4 underflow flag", 32'(err_flags[2]), 32'(m_flags[2]));
    check("R8 healthy", 32'(healthy), 32'(m_flags == 3'b000));
  endtask

  task automatic idle();
    loc_valid = 0; rem_valid = 0; clear_rd = 0;
  endtask

  initial begin
    #(200000 * 8);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int pos = 0, plen = 1;
    void'($urandom(32'd7321));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 flags", 32'(err_flags), 0);
    check("R1 healthy", 32'(healthy), 1);
    check("R1 merge_valid", 32'(merge_valid), 0);

    // R4: pop from empty FIFO
    idle(); rem_valid = 1; rem_data = 16'hBEEF;
    step();
    check("R4 no merge on empty", 32'(merge_valid), 0);
    idle(); step(); step();
    check("R6 underflow held", 32'(err_flags[2]), 1);
    // R7: plain clear
    clear_rd = 1; step(); idle(); step();
    check("R7 cleared", 32'(err_flags), 0);

    // R3: fill DEPTH entries then one extra
    for (int i = 0; i <= DEPTH; i++) begin
      idle(); loc_valid = 1; loc_sop = 1; loc_eop = 1; loc_data = 16'(i + 1);
      step();
    end
    check("R3 overflow set", 32'(err_flags[1]), 1);
    // full with simultaneous pop: write still dropped
    idle(); loc_valid = 1; loc_sop = 1; loc_eop = 1; loc_data = 16'h00AA;
    rem_valid = 1; rem_sop = 1; rem_eop = 1; rem_data = 16'h0100;
    step();
    check("R3 first out", 32'(merge_loc_data), 1);
    // drain remaining, extra beat must not appear
    for (int i = 0; i < DEPTH; i++) begin
      idle(); rem_valid = 1; rem_sop = 1; rem_eop = 1; rem_data = 16'(i);
      step();
    end
    check("R3 dropped beats absent", 32'(merge_valid), 0);

    // R7: clear colliding with an underflow
    idle(); clear_rd = 1; rem_valid = 1; step();
    check("R7 same-cycle error kept", 32'(err_flags), 32'b100);
    idle(); clear_rd = 1; step(); idle(); step();

    // R5: directed misalignment
    idle(); loc_valid = 1; loc_sop = 1; loc_eop = 0; loc_data = 16'h0042; step();
    idle(); rem_valid = 1; rem_sop = 0; rem_eop = 0; rem_data = 16'h0043; step();
    check("R5 misalign set", 32'(err_flags[0]), 1);
    idle(); clear_rd = 1; step(); idle();

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      idle();
      loc_valid = ($urandom_range(0, 99) < 50);
      if (loc_valid) begin
        if (pos == 0) plen = $urandom_range(1, 4);
        loc_sop = (pos == 0);
        loc_eop = (pos == plen - 1);
        loc_data = 16'($urandom);
        pos = (pos == plen - 1) ? 0 : pos + 1;
      end
      rem_valid = ($urandom_range(0, 99) < 48);
      rem_data = 16'($urandom);
      if (q.size() > 0 && $urandom_range(0, 99) < 92) begin
        rem_sop = q[0][W+1]; rem_eop = q[0][W];
      end else begin
        rem_sop = 1'($urandom); rem_eop = 1'($urandom);
      end
      clear_rd = ($urandom_range(0, 99) < 4);
      step();
    end
    idle(); step();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule